// File: doc/BRIEF.md
# Auto-Request Memory-to-Memory DMA Channel

This block is a single memory-to-memory DMA channel programmed through a small word-indexed register file. Software loads a source address, a destination address and a unit count, chooses a unit size and an addressing mode for each side, sets the shared master enable and then the channel enable. From then on the channel runs by itself: it moves one unit after another over a valid/ready memory port until the count is used up. It then raises its end flag, and, when enabled, an interrupt line.

Units larger than the 32-bit data path are carried as a burst of word beats. Each unit is first read into an internal buffer and then written out. Two divided modes move a 16- or 32-byte unit as two half-unit read/write operations. A hold addressing mode keeps every beat on one address, which suits a peripheral data port. Before each unit the channel checks the unit-size code, the alignment of both addresses and whether decrement is legal for that size. A failed check raises the address-error flag without touching the bus.

The controller is a three-state machine. IDLE evaluates the start conditions. The go transition leads to READ, the error transition sets the address-error flag and stays in IDLE, and the done transition sets the end flag and stays in IDLE. READ collects the beats of the current part and moves to WRITE after its last beat. WRITE sends them out. After the last beat it returns to READ for the second half of a divided unit, or to IDLE once the whole unit is complete, updating the addresses and the count.

Top module: `dma_chan`

## Requirements
- R1: After reset every register reads zero (index 0 source, 1 destination, 2 count, 3 control, 4 operation), `irq` is low and `mem_req` is low.
- R2: The 4-bit size code maps 0→1, 1→2, 2→4, 7→8, 3→16 and 4→32 bytes, 11→16 bytes divided and 12→32 bytes divided. Any other code raises the address-error flag when a start is attempted.
- R3: The size code is split in the control register: its upper two bits sit at control bits [21:20] and its lower two bits at control bits [5:4].
- R4: The source mode sits at control bits [9:8] and the destination mode at [11:10]. 0 keeps the unit base fixed, with the beats of a multi-word unit stepping by 4. 1 adds the unit size after each unit. 2 subtracts it. 3 puts every beat of every unit on the same address.
- R5: Units move only while channel enable (control bit 0) and master enable (operation bit 0) are 1, NMI flag (operation bit 1), address-error flag (operation bit 2) and end flag (control bit 1) are 0, and request select (control bits [15:12]) equals 4'b0100.
- R6: The count register is 24 bits (upper bits read 0) and counts units. It drops by one after the last write beat of each unit. While a unit is in flight, writes to source, destination and count are ignored, as are writes to the size, mode and request fields.
- R7: When a started channel finds its count at zero, it sets the end flag, and `irq` equals end flag AND interrupt enable (control bit 2).
- R8: A source or destination address not aligned to the unit size, or decrement mode with a unit larger than 4 bytes, sets the address-error flag and produces no bus beat.
- R9: Each beat holds `mem_req` with a stable address, write flag and write data until `mem_ready`. Units up to 4 bytes use one beat of `mem_size` = log2(bytes), with data in the low bits. Larger units use size/4 word beats (`mem_size` = 2), all reads of a part before its writes. Divided units alternate a half read with a half write.
- R10: The end, address-error and NMI flags are clear-only from software: writing 0 clears a flag, writing 1 leaves it unchanged. A high `nmi_in` sets the NMI flag.
- R11: Source and destination registers keep only the low 29 address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| nmi_in | input | 1 | Non-maskable event, sets the NMI flag |
| irq | output | 1 | Transfer-end interrupt |
| mem_req | output | 1 | Memory beat valid |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 29 | Beat byte address |
| mem_size | output | 2 | log2 of beat bytes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Beat accepted |

## Verification
The bench builds the channel with its defaults: 29 address bits, a 24-bit count and an eight-word unit buffer. The buffer size brings the full 32-byte units, plain and divided, within reach, together with the widest count and address masking. A memory model that stalls one beat in four keeps the hold-while-waiting rule exercised on reads and writes. Every write beat is compared in order against a queue of address, size and data expected for that transfer.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int DW = 32;

    localparam logic [2:0] RI_SRC  = 3'd0;
    localparam logic [2:0] RI_DST  = 3'd1;
    localparam logic [2:0] RI_CNT  = 3'd2;
    localparam logic [2:0] RI_CTRL = 3'd3;
    localparam logic [2:0] RI_OPR  = 3'd4;

    localparam logic [3:0] RS_AUTO = 4'b0100;

    typedef enum logic [1:0] {
        AM_FIXED = 2'd0,
        AM_INC   = 2'd1,
        AM_DEC   = 2'd2,
        AM_HOLD  = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } st_e;

    typedef struct packed {
        logic       ok;
        logic [2:0] lg;
        logic       div;
    } usz_t;
endpackage

// File: rtl/dma_size_dec.sv
module dma_size_dec
    import dma_pkg::*;
(
    input  logic [3:0] code,
    output usz_t       usz
);
    always_comb begin
        unique case (code)
            4'd0:    usz = '{ok: 1'b1, lg: 3'd0, div: 1'b0};
            4'd1:    usz = '{ok: 1'b1, lg: 3'd1, div: 1'b0};
            4'd2:    usz = '{ok: 1'b1, lg: 3'd2, div: 1'b0};
            4'd7:    usz = '{ok: 1'b1, lg: 3'd3, div: 1'b0};
            4'd3:    usz = '{ok: 1'b1, lg: 3'd4, div: 1'b0};
            4'd4:    usz = '{ok: 1'b1, lg: 3'd5, div: 1'b0};
            4'd11:   usz = '{ok: 1'b1, lg: 3'd4, div: 1'b1};
            4'd12:   usz = '{ok: 1'b1, lg: 3'd5, div: 1'b1};
            default: usz = '{ok: 1'b0, lg: 3'd0, div: 1'b0};
        endcase
    end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 29,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic              busy,
    input  logic              nmi_in,
    input  logic              upd,
    input  logic [ADDR_W-1:0] upd_src,
    input  logic [ADDR_W-1:0] upd_dst,
    input  logic [CNT_W-1:0]  upd_cnt,
    input  logic              set_te,
    input  logic              set_ae,
    output logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] dst,
    output logic [CNT_W-1:0]  cnt,
    output logic              de,
    output logic              te,
    output logic              ie,
    output logic [3:0]        size_code,
    output logic [1:0]        smode,
    output logic [1:0]        dmode,
    output logic [3:0]        rs,
    output logic              dme,
    output logic              nmif,
    output logic              ae
);
    logic [1:0] sz_hi, sz_lo;
    logic       wr_src, wr_dst, wr_cnt, wr_ctrl, wr_opr;

    assign size_code = {sz_hi, sz_lo};
    assign wr_src  = we && addr == RI_SRC  && !busy;
    assign wr_dst  = we && addr == RI_DST  && !busy;
    assign wr_cnt  = we && addr == RI_CNT  && !busy;
    assign wr_ctrl = we && addr == RI_CTRL;
    assign wr_opr  = we && addr == RI_OPR;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src <= '0; dst <= '0; cnt <= '0;
            de <= 1'b0; te <= 1'b0; ie <= 1'b0;
            sz_hi <= '0; sz_lo <= '0; smode <= '0; dmode <= '0; rs <= '0;
            dme <= 1'b0; nmif <= 1'b0; ae <= 1'b0;
        end else begin
            if (upd) begin
                src <= upd_src;
                dst <= upd_dst;
                cnt <= upd_cnt;
            end
            if (wr_src) src <= wdata[ADDR_W-1:0];
            if (wr_dst) dst <= wdata[ADDR_W-1:0];
            if (wr_cnt) cnt <= wdata[CNT_W-1:0];
            if (wr_ctrl) begin
                de <= wdata[0];
                ie <= wdata[2];
                if (!busy) begin
                    sz_lo <= wdata[5:4];
                    smode <= wdata[9:8];
                    dmode <= wdata[11:10];
                    rs    <= wdata[15:12];
                    sz_hi <= wdata[21:20];
                end
            end
            if (set_te)       te <= 1'b1;
            else if (wr_ctrl) te <= te & wdata[1];
            if (wr_opr) dme <= wdata[0];
            if (nmi_in)      nmif <= 1'b1;
            else if (wr_opr) nmif <= nmif & wdata[1];
            if (set_ae)      ae <= 1'b1;
            else if (wr_opr) ae <= ae & wdata[2];
        end
    end

    always_comb begin
        unique case (addr)
            RI_SRC:  rdata = DW'(src);
            RI_DST:  rdata = DW'(dst);
            RI_CNT:  rdata = DW'(cnt);
            RI_CTRL: rdata = {10'd0, sz_hi, 4'd0, rs, dmode, smode,
                              2'd0, sz_lo, 1'b0, ie, te, de};
            RI_OPR:  rdata = {29'd0, ae, nmif, dme};
            default: rdata = '0;
        endcase
    end

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_cnt) && cnt != $past(cnt)) |-> cnt == $past(cnt) - 1'b1);

    // R7
    te_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(te) |-> $past(cnt) == '0);
endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
    import dma_pkg::*;
#(
    parameter int ADDR_W    = 29,
    parameter int CNT_W     = 24,
    parameter int BUF_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              de,
    input  logic              te,
    input  logic              dme,
    input  logic              nmif,
    input  logic              ae,
    input  logic [3:0]        rs,
    input  usz_t              usz,
    input  logic [1:0]        smode,
    input  logic [1:0]        dmode,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic [CNT_W-1:0]  cnt,
    output logic              busy,
    output logic              upd,
    output logic [ADDR_W-1:0] nsrc,
    output logic [ADDR_W-1:0] ndst,
    output logic [CNT_W-1:0]  ncnt,
    output logic              set_te,
    output logic              set_ae,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_ready
);
    localparam int BW = $clog2(BUF_WORDS);

    st_e            st, st_n;
    logic [BW-1:0]  bt;
    logic           pt;
    logic [DW-1:0]  dbuf [BUF_WORDS];

    logic [BW:0]        nb_unit, nb_part, part_base;
    logic               last_beat, go, bad, misal, wide, split_more;
    logic [ADDR_W-1:0]  amask, step, off;

    assign wide      = usz.lg > 3'd2;
    assign nb_unit   = wide ? ((BW+1)'(1) << (usz.lg - 3'd2)) : (BW+1)'(1);
    assign nb_part   = usz.div ? (nb_unit >> 1) : nb_unit;
    assign part_base = pt ? nb_part : '0;
    assign last_beat = {1'b0, bt} == part_base + nb_part - 1'b1;
    assign split_more = usz.div && !pt;

    assign amask = ADDR_W'((32'd1 << usz.lg) - 32'd1);
    assign step  = ADDR_W'(32'd1 << usz.lg);
    assign misal = ((src & amask) != '0) || ((dst & amask) != '0);
    assign bad   = !usz.ok || misal ||
                   ((smode == AM_DEC || dmode == AM_DEC) && wide);
    assign go    = de && dme && !ae && !nmif && !te && rs == RS_AUTO;
    assign off   = wide ? ADDR_W'({bt, 2'b00}) : '0;

    // next-state logic
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:  if (go && !bad && cnt != '0) st_n = ST_READ;
            ST_READ:  if (mem_ready && last_beat) st_n = ST_WRITE;
            ST_WRITE: if (mem_ready && last_beat)
                          st_n = split_more ? ST_READ : ST_IDLE;
            default:  st_n = ST_IDLE;
        endcase
    end

    // state register and beat counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
            bt <= '0;
            pt <= 1'b0;
        end else begin
            st <= st_n;
            unique case (st)
                ST_IDLE: begin
                    bt <= '0;
                    pt <= 1'b0;
                end
                ST_READ: if (mem_ready)
                    bt <= last_beat ? BW'(part_base) : bt + 1'b1;
                ST_WRITE: if (mem_ready) begin
                    if (!last_beat)      bt <= bt + 1'b1;
                    else if (split_more) begin
                        pt <= 1'b1;
                        bt <= BW'(nb_part);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (st == ST_READ && mem_ready) dbuf[bt] <= mem_rdata;
    end

    // outputs
    always_comb begin
        busy      = st != ST_IDLE;
        mem_req   = st != ST_IDLE;
        mem_we    = st == ST_WRITE;
        mem_size  = wide ? 2'd2 : usz.lg[1:0];
        mem_wdata = dbuf[bt];
        mem_addr  = (st == ST_WRITE) ? dst + ((dmode == AM_HOLD) ? '0 : off)
                                     : src + ((smode == AM_HOLD) ? '0 : off);
        set_ae    = st == ST_IDLE && go && bad;
        set_te    = st == ST_IDLE && go && !bad && cnt == '0;
        upd       = st == ST_WRITE && mem_ready && last_beat && !split_more;
        ncnt      = cnt - 1'b1;
        unique case (smode)
            AM_INC:  nsrc = src + step;
            AM_DEC:  nsrc = src - step;
            default: nsrc = src;
        endcase
        unique case (dmode)
            AM_INC:  ndst = dst + step;
            AM_DEC:  ndst = dst - step;
            default: ndst = dst;
        endcase
    end

    // R9
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                     $stable(mem_we) && $stable(mem_wdata)));

    // R5
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(de && dme && !ae && !nmif && !te && rs == RS_AUTO));
endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int ADDR_W    = 29,
    parameter int CNT_W     = 24,
    parameter int BUF_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              nmi_in,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ready
);
    logic [ADDR_W-1:0] src, dst, nsrc, ndst;
    logic [CNT_W-1:0]  cnt, ncnt;
    logic              de, te, ie, dme, nmif, ae;
    logic              busy, upd, set_te, set_ae;
    logic [3:0]        size_code, rs;
    logic [1:0]        smode, dmode;
    usz_t              usz;

    dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .nmi_in(nmi_in),
        .upd(upd), .upd_src(nsrc), .upd_dst(ndst), .upd_cnt(ncnt),
        .set_te(set_te), .set_ae(set_ae), .src(src), .dst(dst), .cnt(cnt),
        .de(de), .te(te), .ie(ie), .size_code(size_code), .smode(smode),
        .dmode(dmode), .rs(rs), .dme(dme), .nmif(nmif), .ae(ae)
    );

    dma_size_dec u_sdec (.code(size_code), .usz(usz));

    dma_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUF_WORDS(BUF_WORDS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .de(de), .te(te), .dme(dme), .nmif(nmif),
        .ae(ae), .rs(rs), .usz(usz), .smode(smode), .dmode(dmode),
        .src(src), .dst(dst), .cnt(cnt), .busy(busy), .upd(upd),
        .nsrc(nsrc), .ndst(ndst), .ncnt(ncnt), .set_te(set_te),
        .set_ae(set_ae), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    assign irq = te && ie;

    // R8
    ae_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ae) |-> !mem_req);
endmodule

// File: tb/dma_chan_tb.sv
`timescale 1ns/1ps
module dma_chan_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        nmi_in = 1'b0;
    logic        irq, mem_req, mem_we;
    logic [28:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;
    logic [1:0]  stall = '0;

    int checks = 0;
    int errors = 0;
    int beats  = 0;

    logic [28:0] q_addr [$];
    logic [31:0] q_data [$];
    logic [1:0]  q_size [$];

    always #4 clk = ~clk;

    dma_chan u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_in(nmi_in),
        .irq(irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready)
    );

    function automatic logic [7:0] pat(input logic [28:0] a);
        return 8'(a * 7 + 3);
    endfunction

    assign mem_rdata = {pat(mem_addr + 3), pat(mem_addr + 2),
                        pat(mem_addr + 1), pat(mem_addr)};

    always @(posedge clk) begin
        stall     <= stall + 1'b1;
        mem_ready <= (stall != 2'd3);
    end

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: every write beat is compared with the queue head
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_ready) begin
            beats++;
            if (mem_we) begin
                if (q_addr.size() == 0) begin
                    check("R9 unexpected write beat", {3'd0, mem_addr}, 32'hFFFFFFFF);
                end else begin
                    logic [28:0] ea;
                    logic [31:0] ed, msk;
                    logic [1:0]  es;
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    es = q_size.pop_front();
                    msk = (es == 2'd0) ? 32'hFF : (es == 2'd1) ? 32'hFFFF : 32'hFFFFFFFF;
                    check("R4 write address", {3'd0, mem_addr}, {3'd0, ea});
                    check("R9 beat size", {30'd0, mem_size}, {30'd0, es});
                    check("R2 write data", mem_wdata & msk, ed);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input logic [3:0] code,
        input logic [1:0] sm, input logic [1:0] dm, input logic ie);
        return (32'(code[3:2]) << 20) | (32'(dm) << 10) | (32'(sm) << 8) |
               (32'h4 << 12) | (32'(code[1:0]) << 4) | (32'(ie) << 2) | 32'h1;
    endfunction

    function automatic logic [28:0] adv(input logic [28:0] a, input logic [1:0] m,
                                        input int bytes);
        if (m == 2'd1) return a + 29'(bytes);
        if (m == 2'd2) return a - 29'(bytes);
        return a;
    endfunction

    task automatic run_xfer(input string tag, input logic [3:0] code,
        input int bytes, input logic [1:0] sm, input logic [1:0] dm,
        input logic [28:0] s, input logic [28:0] d, input int n,
        input logic ie, input bit poke);
        logic [28:0] su, du;
        logic [31:0] v;
        int nbeats, bb;
        bit done;
        nbeats = (bytes > 4) ? bytes / 4 : 1;
        bb     = (bytes > 4) ? 4 : bytes;
        su = s; du = d;
        for (int u = 0; u < n; u++) begin
            for (int b = 0; b < nbeats; b++) begin
                logic [28:0] sa, da;
                logic [31:0] dat;
                sa = su + ((sm == 2'd3) ? 29'd0 : 29'(b * 4));
                da = du + ((dm == 2'd3) ? 29'd0 : 29'(b * 4));
                dat = '0;
                for (int k = 0; k < bb; k++) dat[8*k +: 8] = pat(sa + 29'(k));
                q_addr.push_back(da);
                q_data.push_back(dat);
                q_size.push_back((bb == 4) ? 2'd2 : (bb == 2) ? 2'd1 : 2'd0);
            end
            su = adv(su, sm, bytes);
            du = adv(du, dm, bytes);
        end
        wr(3'd0, {3'd0, s});
        wr(3'd1, {3'd0, d});
        wr(3'd2, 32'(n));
        wr(3'd4, 32'h1);
        wr(3'd3, ctrl_word(code, sm, dm, ie));
        if (poke) begin
            repeat (3) @(negedge clk);
            wr(3'd2, 32'd100);
            wr(3'd0, 32'h0);
        end
        done = 1'b0;
        for (int i = 0; i < 4000 && !done; i++) begin
            @(negedge clk);
            rd(3'd3, v);
            done = v[1];
        end
        repeat (2) @(negedge clk);
        check({tag, " R7 end flag set"}, {31'd0, done}, 32'd1);
        check({tag, " R7 irq"}, {31'd0, irq}, {31'd0, ie});
        rd(3'd2, v); check({tag, " R6 count zero"}, v, 32'd0);
        rd(3'd0, v); check({tag, " R4 final source"}, v, {3'd0, su});
        rd(3'd1, v); check({tag, " R4 final dest"}, v, {3'd0, du});
        check({tag, " R9 all beats seen"}, q_addr.size(), 0);
        wr(3'd3, 32'h2);
        rd(3'd3, v); check({tag, " R10 end flag keeps on write 1"}, {31'd0, v[1]}, 32'd1);
        wr(3'd3, 32'h0);
        rd(3'd3, v); check({tag, " R10 end flag cleared"}, {31'd0, v[1]}, 32'd0);
        check({tag, " R7 irq drops"}, {31'd0, irq}, 32'd0);
        wr(3'd4, 32'h0);
        q_addr.delete(); q_data.delete(); q_size.delete();
    endtask

    task automatic no_run(input string tag, input logic [31:0] opr,
        input logic [31:0] ctrl, input logic [28:0] s, input logic [28:0] d,
        input logic exp_ae);
        int b0;
        logic [31:0] v;
        wr(3'd0, {3'd0, s});
        wr(3'd1, {3'd0, d});
        wr(3'd2, 32'd2);
        wr(3'd4, opr);
        b0 = beats;
        wr(3'd3, ctrl);
        repeat (20) @(negedge clk);
        check({tag, " no bus beat"}, beats, b0);
        rd(3'd4, v); check({tag, " address-error flag"}, {31'd0, v[2]}, {31'd0, exp_ae});
        rd(3'd3, v); check({tag, " end flag stays clear"}, {31'd0, v[1]}, 32'd0);
        rd(3'd2, v); check({tag, " count untouched"}, v, 32'd2);
        wr(3'd3, 32'h0);
        wr(3'd4, 32'h0);
        rd(3'd4, v); check({tag, " R10 flags cleared by 0"}, v, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int r = 0; r < 5; r++) begin
            rd(3'(r), v);
            check("R1 register reset", v, 32'd0);
        end
        check("R1 irq low", {31'd0, irq}, 32'd0);
        check("R1 no request", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 no request after release", {31'd0, mem_req}, 32'd0);

        // R11 address masking, R6 count width
        wr(3'd0, 32'hFFFFFFFF); rd(3'd0, v); check("R11 source 29 bits", v, 32'h1FFFFFFF);
        wr(3'd1, 32'hFFFFFFFF); rd(3'd1, v); check("R11 dest 29 bits", v, 32'h1FFFFFFF);
        wr(3'd2, 32'hFFFFFFFF); rd(3'd2, v); check("R6 count 24 bits", v, 32'h00FFFFFF);
        // R3 split size field placement
        wr(3'd3, 32'h00300030); rd(3'd3, v); check("R3 size halves", v, 32'h00300030);
        wr(3'd3, 32'h0);

        run_xfer("w4inc", 4'd2, 4, 2'd1, 2'd1, 29'h100, 29'h800, 5, 1'b1, 1'b0);
        run_xfer("b1fix", 4'd0, 1, 2'd1, 2'd0, 29'h013, 29'h900, 3, 1'b1, 1'b0);
        run_xfer("h2dec", 4'd1, 2, 2'd2, 2'd1, 29'h102, 29'hA00, 4, 1'b1, 1'b0);
        run_xfer("R3 d8",   4'd7, 8, 2'd1, 2'd1, 29'h040, 29'h840, 2, 1'b1, 1'b0);
        run_xfer("R2 q16",  4'd3, 16, 2'd0, 2'd1, 29'h060, 29'h880, 2, 1'b1, 1'b0);
        run_xfer("R2 o32",  4'd4, 32, 2'd1, 2'd1, 29'h080, 29'hC00, 2, 1'b1, 1'b1);
        run_xfer("R9 div16", 4'd11, 16, 2'd3, 2'd1, 29'h0A0, 29'hD00, 2, 1'b1, 1'b0);
        run_xfer("R9 div32", 4'd12, 32, 2'd1, 2'd3, 29'h0C0, 29'hE00, 2, 1'b0, 1'b0);
        run_xfer("R7 ie0", 4'd2, 4, 2'd1, 2'd1, 29'h200, 29'hF00, 1, 1'b0, 1'b0);

        // R8 address errors and R2 invalid size code
        no_run("R8 misaligned src", 32'h1, ctrl_word(4'd2, 2'd1, 2'd1, 1'b1), 29'h101, 29'h800, 1'b1);
        no_run("R8 misaligned dst", 32'h1, ctrl_word(4'd4, 2'd1, 2'd1, 1'b1), 29'h100, 29'h810, 1'b1);
        no_run("R8 decrement 8B", 32'h1, ctrl_word(4'd7, 2'd2, 2'd1, 1'b1), 29'h100, 29'h800, 1'b1);
        no_run("R2 invalid code", 32'h1, ctrl_word(4'd5, 2'd1, 2'd1, 1'b1), 29'h100, 29'h800, 1'b1);
        // R5 gating
        no_run("R5 master off", 32'h0, ctrl_word(4'd2, 2'd1, 2'd1, 1'b1), 29'h100, 29'h800, 1'b0);
        no_run("R5 wrong request", 32'h1, ctrl_word(4'd2, 2'd1, 2'd1, 1'b1) & ~32'h4000 | 32'h1000,
               29'h100, 29'h800, 1'b0);

        // R10 NMI flag
        @(negedge clk); nmi_in = 1'b1;
        @(negedge clk); nmi_in = 1'b0;
        rd(3'd4, v); check("R10 nmi sets flag", {31'd0, v[1]}, 32'd1);
        wr(3'd4, 32'h3);
        rd(3'd4, v); check("R10 nmi flag keeps on write 1", {31'd0, v[1]}, 32'd1);
        begin
            int b0;
            b0 = beats;
            wr(3'd0, 32'h100); wr(3'd1, 32'h800); wr(3'd2, 32'd1);
            wr(3'd3, ctrl_word(4'd2, 2'd1, 2'd1, 1'b1));
            repeat (20) @(negedge clk);
            check("R5 nmi flag blocks", beats, b0);
            wr(3'd3, 32'h0);
        end
        wr(3'd4, 32'h0);
        rd(3'd4, v); check("R10 nmi flag cleared", v, 32'd0);

        run_xfer("R5 after clear", 4'd2, 4, 2'd1, 2'd1, 29'h100, 29'h800, 1, 1'b1, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule